// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block sits between a memory client and the memory controller of a graphics engine. It rewrites client addresses through one flat, single-level page table held in memory. A request whose address falls inside the programmed translation window is turned into a page number. The block fetches that page's 64-bit table entry through a simple read port, checks the permission bits in it, and joins the entry's physical page number with the untouched 12-bit page offset. Requests that fall outside the window but inside the system window leave unchanged. When translation is switched off, every request leaves unchanged. Requests that fall in neither window, or that are refused by an entry, are handled differently by direction. A refused read goes to a programmable default address. A refused write is dropped and raises a sticky fault flag.

A one-entry cache keeps the most recently fetched entry. A repeat access to that page finishes in one cycle. A miss holds the client off through `req_ready` until the entry read returns. Software empties the cache by holding the flush input high for at least one cycle.

Top module: `flat_xlate_unit`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid`, `mem_req` and `fault_sticky` are all 0.
- R2: When either `cfg_global_en` or `cfg_ctx_en` is 0, every request is answered in the cycle after acceptance with `rsp_kind`=0 (pass) and `rsp_addr` equal to `req_addr`. No entry fetch is made.
- R3: On a cache miss inside the window, `mem_req` pulses for exactly one cycle, in the cycle after acceptance. `mem_addr` = `cfg_table_base` + ((`req_addr` - `cfg_flat_start`) >> 12) * 8. `req_ready` stays 0 until the response has been issued.
- R4: An allowed access returns `rsp_kind`=1 (translated) and `rsp_addr` = {entry[AW-1:12], `req_addr`[11:0]}. `rsp_system` is entry bit 1 and `rsp_snoop` is entry bit 2. On a miss, the response comes in the cycle after `mem_rvalid`.
- R5: The translation window includes both `cfg_flat_start` and `cfg_flat_end`. An address outside the window but within `cfg_sys_low`..`cfg_sys_high` (both inclusive) passes through with `rsp_kind`=0.
- R6: When translation is on and an address lies in neither window, the response depends on direction. A read returns `rsp_kind`=2 with `rsp_addr`=`cfg_default_addr`. A write returns `rsp_kind`=3 (dropped) with `rsp_addr`=0 and sets `fault_sticky`.
- R7: A read is redirected to `cfg_default_addr` (`rsp_kind`=2) when the entry's valid bit (bit 0) or readable bit (bit 5) is 0.
- R8: A write is dropped (`rsp_kind`=3, `rsp_addr`=0) when the entry's valid bit (bit 0) or writeable bit (bit 6) is 0. It sets `fault_sticky`, which then stays 1 until reset.
- R9: An access to the same page as the cached entry is answered in the cycle after acceptance, without a fetch.
- R10: Holding `cfg_flush` high for one cycle empties the cache, so the next access to the previously cached page fetches its entry again.
- R11: A miss to a different page replaces the cached entry, so returning to the earlier page fetches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_global_en | input | 1 | Global page-table enable |
| cfg_ctx_en | input | 1 | Enable of the single translation context |
| cfg_flush | input | 1 | Cache invalidate, active high |
| cfg_table_base | input | AW | Byte address of entry 0 |
| cfg_flat_start | input | AW | First address of the translation window (page aligned) |
| cfg_flat_end | input | AW | Last address of the translation window |
| cfg_sys_low | input | AW | First address of the passthrough window |
| cfg_sys_high | input | AW | Last address of the passthrough window |
| cfg_default_addr | input | AW | Target of refused reads |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Client address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| mem_req | output | 1 | Entry read request, one-cycle pulse |
| mem_addr | output | AW | Byte address of the entry to read |
| mem_rvalid | input | 1 | Entry read data valid |
| mem_rdata | input | 64 | Entry read data |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_addr | output | AW | Resulting address |
| rsp_kind | output | 2 | 0 pass, 1 translated, 2 default redirect, 3 dropped |
| rsp_system | output | 1 | Entry says system memory |
| rsp_snoop | output | 1 | Entry says snooped |
| fault_sticky | output | 1 | A write has been dropped since reset |

## Verification
The bench aims at the window edges: the first and last window addresses must translate, to page 0 and to the last page, and the address one past the end must fall through to the passthrough window. An off-by-one compare would translate or pass the wrong one of these. Permission tests flip single entry bits and check that a read only needs the readable bit and a write only needs the writeable bit, so swapped bit positions show up as wrong redirects. The cache is tested with a repeat access, which must not fetch. A flush and a page change must each force a new fetch, so a cache that ignores flush or compares the wrong tag returns a stale physical page. A design that sets the fault flag only for a single cycle would fail the check that the flag holds through a later allowed access.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int PAGE_SHIFT  = 12;
  localparam int ENTRY_SHIFT = 3;
  localparam int PTE_W       = 64;

  localparam int PTE_VALID = 0;
  localparam int PTE_SYS   = 1;
  localparam int PTE_SNOOP = 2;
  localparam int PTE_READ  = 5;
  localparam int PTE_WRITE = 6;

  typedef enum logic [1:0] {
    KIND_PASS    = 2'd0,
    KIND_XLATE   = 2'd1,
    KIND_DEFAULT = 2'd2,
    KIND_DROP    = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    REGION_PASS,
    REGION_FLAT,
    REGION_UNMAPPED
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } xst_e;

  function automatic logic pte_allows(input logic [PTE_W-1:0] pte, input logic wr);
    pte_allows = pte[PTE_VALID] && (wr ? pte[PTE_WRITE] : pte[PTE_READ]);
  endfunction
endpackage

// File: rtl/xlate_decode.sv
module xlate_decode
  import xlate_pkg::*;
#(
  parameter int AW = 40,
  localparam int IW = AW - PAGE_SHIFT
) (
  input  logic [AW-1:0] addr,
  input  logic          xlate_on,
  input  logic [AW-1:0] flat_start,
  input  logic [AW-1:0] flat_end,
  input  logic [AW-1:0] sys_low,
  input  logic [AW-1:0] sys_high,
  output region_e       region,
  output logic [IW-1:0] page_idx
);
  logic          in_flat;
  logic          in_sys;
  logic [AW-1:0] offset;

  assign in_flat  = (addr >= flat_start) && (addr <= flat_end);
  assign in_sys   = (addr >= sys_low) && (addr <= sys_high);
  assign offset   = addr - flat_start;
  assign page_idx = offset[AW-1:PAGE_SHIFT];

  always_comb begin
    if (!xlate_on)    region = REGION_PASS;
    else if (in_flat) region = REGION_FLAT;
    else if (in_sys)  region = REGION_PASS;
    else              region = REGION_UNMAPPED;
  end
endmodule

// File: rtl/xlate_entry_cache.sv
module xlate_entry_cache
  import xlate_pkg::*;
#(
  parameter int IW = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [IW-1:0]    fill_idx,
  input  logic [PTE_W-1:0] fill_pte,
  input  logic [IW-1:0]    look_idx,
  output logic             hit,
  output logic [PTE_W-1:0] hit_pte
);
  logic             vld_q, vld_d;
  logic [IW-1:0]    tag_q;
  logic [PTE_W-1:0] pte_q;

  always_comb begin
    vld_d = vld_q;
    if (flush)        vld_d = 1'b0;
    else if (fill_en) vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q <= fill_idx;
      pte_q <= fill_pte;
    end
  end

  assign hit     = vld_q && (tag_q == look_idx);
  assign hit_pte = pte_q;
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int AW = 40,
  localparam int IW = AW - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  output logic             req_ready,
  input  region_e          region,
  input  logic [IW-1:0]    page_idx,
  input  logic [AW-1:0]    table_base,
  input  logic [AW-1:0]    default_addr,
  input  logic             cache_hit,
  input  logic [PTE_W-1:0] cache_pte,
  output logic             fill_en,
  output logic [IW-1:0]    fill_idx,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             rsp_valid,
  output logic [AW-1:0]    rsp_addr,
  output logic [1:0]       rsp_kind,
  output logic             rsp_system,
  output logic             rsp_snoop,
  output logic             fault_sticky
);
  xst_e            st_q, st_d;
  logic            hold_en;
  logic [AW-1:0]   hold_addr_q;
  logic            hold_wr_q;
  logic [IW-1:0]   hold_idx_q;
  logic [AW-1:0]   idx_ext;

  logic            in_wait;
  logic [AW-1:0]   sel_addr;
  logic            sel_wr;
  logic [PTE_W-1:0] sel_pte;
  logic            sel_ok;

  rsp_kind_e       ok_kind, deny_kind, kind_d;
  logic [AW-1:0]   ok_addr, deny_addr, addr_d;
  logic            rsp_v_d, sys_d, snp_d, fault_d, fault_q;
  logic            use_deny, use_pass;

  assign req_ready = (st_q == ST_IDLE);
  assign mem_req   = (st_q == ST_ISSUE);
  assign idx_ext   = AW'(hold_idx_q);
  assign mem_addr  = table_base + (idx_ext << ENTRY_SHIFT);
  assign in_wait   = (st_q == ST_WAIT);
  assign fill_en   = in_wait && mem_rvalid;
  assign fill_idx  = hold_idx_q;

  assign sel_addr = in_wait ? hold_addr_q : req_addr;
  assign sel_wr   = in_wait ? hold_wr_q   : req_write;
  assign sel_pte  = in_wait ? mem_rdata   : cache_pte;
  assign sel_ok   = pte_allows(sel_pte, sel_wr);

  assign ok_kind   = KIND_XLATE;
  assign ok_addr   = {sel_pte[AW-1:PAGE_SHIFT], sel_addr[PAGE_SHIFT-1:0]};
  assign deny_kind = sel_wr ? KIND_DROP : KIND_DEFAULT;
  assign deny_addr = sel_wr ? '0 : default_addr;

  always_comb begin
    st_d     = st_q;
    rsp_v_d  = 1'b0;
    hold_en  = 1'b0;
    use_deny = 1'b0;
    use_pass = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          unique case (region)
            REGION_PASS: begin
              rsp_v_d  = 1'b1;
              use_pass = 1'b1;
            end
            REGION_UNMAPPED: begin
              rsp_v_d  = 1'b1;
              use_deny = 1'b1;
            end
            default: begin
              if (cache_hit) begin
                rsp_v_d  = 1'b1;
                use_deny = !sel_ok;
              end else begin
                hold_en = 1'b1;
                st_d    = ST_ISSUE;
              end
            end
          endcase
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      default: begin
        if (mem_rvalid) begin
          rsp_v_d  = 1'b1;
          use_deny = !sel_ok;
          st_d     = ST_IDLE;
        end
      end
    endcase
  end

  always_comb begin
    if (use_pass) begin
      kind_d = KIND_PASS;
      addr_d = sel_addr;
      sys_d  = 1'b0;
      snp_d  = 1'b0;
    end else if (use_deny) begin
      kind_d = deny_kind;
      addr_d = deny_addr;
      sys_d  = 1'b0;
      snp_d  = 1'b0;
    end else begin
      kind_d = ok_kind;
      addr_d = ok_addr;
      sys_d  = sel_pte[PTE_SYS];
      snp_d  = sel_pte[PTE_SNOOP];
    end
    fault_d = fault_q | (rsp_v_d && (kind_d == KIND_DROP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rsp_valid <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      st_q      <= st_d;
      rsp_valid <= rsp_v_d;
      fault_q   <= fault_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en) begin
      hold_addr_q <= req_addr;
      hold_wr_q   <= req_write;
      hold_idx_q  <= page_idx;
    end
    if (rsp_v_d) begin
      rsp_addr   <= addr_d;
      rsp_kind   <= kind_d;
      rsp_system <= sys_d;
      rsp_snoop  <= snp_d;
    end
  end

  assign fault_sticky = fault_q;
endmodule

// File: rtl/flat_xlate_unit.sv
module flat_xlate_unit
  import xlate_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_global_en,
  input  logic          cfg_ctx_en,
  input  logic          cfg_flush,
  input  logic [AW-1:0] cfg_table_base,
  input  logic [AW-1:0] cfg_flat_start,
  input  logic [AW-1:0] cfg_flat_end,
  input  logic [AW-1:0] cfg_sys_low,
  input  logic [AW-1:0] cfg_sys_high,
  input  logic [AW-1:0] cfg_default_addr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic [1:0]    rsp_kind,
  output logic          rsp_system,
  output logic          rsp_snoop,
  output logic          fault_sticky
);
  localparam int IW = AW - PAGE_SHIFT;

  region_e          region;
  logic [IW-1:0]    page_idx;
  logic             cache_hit;
  logic [PTE_W-1:0] cache_pte;
  logic             fill_en;
  logic [IW-1:0]    fill_idx;

  xlate_decode #(.AW(AW)) i_decode (
    .addr       (req_addr),
    .xlate_on   (cfg_global_en && cfg_ctx_en),
    .flat_start (cfg_flat_start),
    .flat_end   (cfg_flat_end),
    .sys_low    (cfg_sys_low),
    .sys_high   (cfg_sys_high),
    .region     (region),
    .page_idx   (page_idx)
  );

  xlate_entry_cache #(.IW(IW)) i_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (cfg_flush),
    .fill_en  (fill_en),
    .fill_idx (fill_idx),
    .fill_pte (mem_rdata),
    .look_idx (page_idx),
    .hit      (cache_hit),
    .hit_pte  (cache_pte)
  );

  xlate_ctrl #(.AW(AW)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_write    (req_write),
    .req_ready    (req_ready),
    .region       (region),
    .page_idx     (page_idx),
    .table_base   (cfg_table_base),
    .default_addr (cfg_default_addr),
    .cache_hit    (cache_hit),
    .cache_pte    (cache_pte),
    .fill_en      (fill_en),
    .fill_idx     (fill_idx),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .rsp_valid    (rsp_valid),
    .rsp_addr     (rsp_addr),
    .rsp_kind     (rsp_kind),
    .rsp_system   (rsp_system),
    .rsp_snoop    (rsp_snoop),
    .fault_sticky (fault_sticky)
  );
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_global_en,
  input logic          cfg_ctx_en,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req,
  input logic          mem_rvalid,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_addr,
  input logic [1:0]    rsp_kind,
  input logic          fault_sticky
);
  assert_busy_while_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  assert_fetch_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_no_fetch_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(cfg_global_en && cfg_ctx_en)) |=> !mem_req);

  assert_rsp_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rvalid)));

  assert_fault_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_sticky |=> fault_sticky);

  assert_drop_zero_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd3) |-> (rsp_addr == '0 && fault_sticky));
endmodule

bind flat_xlate_unit xlate_checker #(.AW(AW)) i_xlate_checker (.*);

// File: tb/test_flat_xlate_unit.sv
module test_flat_xlate_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;
  localparam logic [AW-1:0] TBL   = 40'h00_2000_0000;
  localparam logic [AW-1:0] FST   = 40'h00_1000_0000;
  localparam logic [AW-1:0] FEND  = 40'h00_100F_FFFF;
  localparam logic [AW-1:0] SLO   = 40'h00_0000_0000;
  localparam logic [AW-1:0] SHI   = 40'h00_3FFF_FFFF;
  localparam logic [AW-1:0] DFLT  = 40'h00_DEAD_0000;
  localparam logic [AW-1:0] FAR   = 40'h80_0000_0000;

  logic clk, rst_n;
  logic cfg_global_en, cfg_ctx_en, cfg_flush;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr, mem_addr, rsp_addr;
  logic mem_req, mem_rvalid;
  logic [63:0] mem_rdata;
  logic rsp_valid, rsp_system, rsp_snoop, fault_sticky;
  logic [1:0] rsp_kind;

  int n_checks = 0;
  int n_fails = 0;
  int fetches = 0;
  logic [AW-1:0] last_fetch_addr;
  logic [7:0] flags [256];

  flat_xlate_unit #(.AW(AW)) i_flat_xlate_unit (
    .clk(clk), .rst_n(rst_n),
    .cfg_global_en(cfg_global_en), .cfg_ctx_en(cfg_ctx_en), .cfg_flush(cfg_flush),
    .cfg_table_base(TBL), .cfg_flat_start(FST), .cfg_flat_end(FEND),
    .cfg_sys_low(SLO), .cfg_sys_high(SHI), .cfg_default_addr(DFLT),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind),
    .rsp_system(rsp_system), .rsp_snoop(rsp_snoop), .fault_sticky(fault_sticky)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] phys_page(input int idx);
    phys_page = 40'h80000 + AW'(idx * 3);
  endfunction

  function automatic logic [63:0] entry_of(input int idx);
    entry_of = (64'(phys_page(idx)) << 12) | 64'(flags[idx]);
  endfunction

  function automatic logic [AW-1:0] xl(input int idx, input logic [AW-1:0] a);
    xl = (phys_page(idx) << 12) | (a & 40'hFFF);
  endfunction

  // memory model: answers an entry read three edges after the request
  int pend = 0;
  int cnt = 0;
  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      pend = 1;
      cnt = 2;
      last_fetch_addr = mem_addr;
      fetches++;
    end else if (pend != 0) begin
      cnt--;
      if (cnt == 0) begin
        pend = 0;
        mem_rvalid <= 1'b1;
        mem_rdata  <= entry_of(int'((last_fetch_addr - TBL) >> 3));
      end
    end
  end

  task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [AW-1:0] a, input logic w,
                        output logic [1:0] kind, output logic [AW-1:0] ra,
                        output logic sys, output logic snp, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    kind = rsp_kind; ra = rsp_addr; sys = rsp_system; snp = rsp_snoop;
  endtask

  logic [1:0] k; logic [AW-1:0] ra; logic s, n; int lat; int f0;

  task automatic t_reset;
    check("R1 ready", req_ready === 1'b1, 64'(req_ready), 1);
    check("R1 rsp_valid", rsp_valid === 1'b0, 64'(rsp_valid), 0);
    check("R1 mem_req", mem_req === 1'b0, 64'(mem_req), 0);
    check("R1 fault", fault_sticky === 1'b0, 64'(fault_sticky), 0);
  endtask

  task automatic t_disabled;
    cfg_ctx_en = 1'b0; f0 = fetches;
    access(FST + 40'h1234, 1'b0, k, ra, s, n, lat);
    check("R2 kind ctx off", k == 2'd0, 64'(k), 0);
    check("R2 addr ctx off", ra == FST + 40'h1234, 64'(ra), 64'(FST + 40'h1234));
    check("R2 latency", lat == 1, 64'(lat), 1);
    cfg_ctx_en = 1'b1; cfg_global_en = 1'b0;
    access(FST + 40'h5678, 1'b1, k, ra, s, n, lat);
    check("R2 addr global off", ra == FST + 40'h5678 && k == 2'd0, 64'(ra), 64'(FST + 40'h5678));
    check("R2 no fetch", fetches == f0, 64'(fetches), 64'(f0));
    cfg_global_en = 1'b1;
  endtask

  task automatic t_miss_hit;
    f0 = fetches;
    access(FST + 40'h2345, 1'b0, k, ra, s, n, lat);
    check("R3 fetch count", fetches == f0 + 1, 64'(fetches), 64'(f0 + 1));
    check("R3 entry addr", last_fetch_addr == TBL + 40'd16, 64'(last_fetch_addr), 64'(TBL + 40'd16));
    check("R4 kind", k == 2'd1, 64'(k), 1);
    check("R4 addr", ra == xl(2, FST + 40'h2345), 64'(ra), 64'(xl(2, FST + 40'h2345)));
    check("R4 sys/snoop", s && n, 64'({s, n}), 3);
    check("R4 latency", lat == 4, 64'(lat), 4);
    access(FST + 40'h20AB, 1'b1, k, ra, s, n, lat);
    check("R9 hit latency", lat == 1, 64'(lat), 1);
    check("R9 no fetch", fetches == f0 + 1, 64'(fetches), 64'(f0 + 1));
    check("R9 hit addr", ra == xl(2, FST + 40'h20AB) && k == 2'd1, 64'(ra), 64'(xl(2, FST + 40'h20AB)));
  endtask

  task automatic t_replace;
    f0 = fetches;
    access(FST + 40'h5010, 1'b0, k, ra, s, n, lat);
    check("R11 new page fetch", fetches == f0 + 1 && ra == xl(5, FST + 40'h5010), 64'(ra), 64'(xl(5, FST + 40'h5010)));
    access(FST + 40'h2010, 1'b0, k, ra, s, n, lat);
    check("R11 old page refetch", fetches == f0 + 2, 64'(fetches), 64'(f0 + 2));
  endtask

  task automatic t_bounds;
    access(FST, 1'b0, k, ra, s, n, lat);
    check("R5 start inclusive", k == 2'd1 && ra == xl(0, FST), 64'(ra), 64'(xl(0, FST)));
    access(FEND, 1'b0, k, ra, s, n, lat);
    check("R5 end inclusive", k == 2'd1 && ra == xl(255, FEND), 64'(ra), 64'(xl(255, FEND)));
    check("R3 last entry addr", last_fetch_addr == TBL + 40'd2040, 64'(last_fetch_addr), 64'(TBL + 40'd2040));
    access(FEND + 40'd1, 1'b0, k, ra, s, n, lat);
    check("R5 past end passes", k == 2'd0 && ra == FEND + 40'd1, 64'(ra), 64'(FEND + 40'd1));
    access(40'h1234, 1'b1, k, ra, s, n, lat);
    check("R5 system window", k == 2'd0 && ra == 40'h1234, 64'(ra), 64'h1234);
  endtask

  task automatic t_perm;
    flags[7] = 8'h41;
    access(FST + 40'h7004, 1'b0, k, ra, s, n, lat);
    check("R7 not readable", k == 2'd2 && ra == DFLT, 64'(ra), 64'(DFLT));
    flags[8] = 8'h60;
    access(FST + 40'h8004, 1'b0, k, ra, s, n, lat);
    check("R7 invalid read", k == 2'd2 && ra == DFLT, 64'(ra), 64'(DFLT));
    check("R8 no fault from reads", fault_sticky == 1'b0, 64'(fault_sticky), 0);
    flags[9] = 8'h21;
    access(FST + 40'h9004, 1'b1, k, ra, s, n, lat);
    check("R8 write dropped", k == 2'd3 && ra == '0, 64'(k), 3);
    check("R8 fault set", fault_sticky == 1'b1, 64'(fault_sticky), 1);
    access(FST + 40'h9008, 1'b0, k, ra, s, n, lat);
    check("R8 read allowed", k == 2'd1 && ra == xl(9, FST + 40'h9008) && !s, 64'(ra), 64'(xl(9, FST + 40'h9008)));
    check("R8 fault holds", fault_sticky == 1'b1, 64'(fault_sticky), 1);
  endtask

  task automatic t_outside;
    access(FAR, 1'b0, k, ra, s, n, lat);
    check("R6 unmapped read", k == 2'd2 && ra == DFLT, 64'(ra), 64'(DFLT));
    access(FAR + 40'h10, 1'b1, k, ra, s, n, lat);
    check("R6 unmapped write", k == 2'd3 && ra == '0, 64'(k), 3);
  endtask

  task automatic t_flush;
    access(FST + 40'h3000, 1'b0, k, ra, s, n, lat);
    f0 = fetches;
    access(FST + 40'h3010, 1'b0, k, ra, s, n, lat);
    check("R10 cached before flush", fetches == f0, 64'(fetches), 64'(f0));
    @(negedge clk); cfg_flush = 1'b1;
    @(negedge clk); cfg_flush = 1'b0;
    access(FST + 40'h3020, 1'b0, k, ra, s, n, lat);
    check("R10 refetch after flush", fetches == f0 + 1 && ra == xl(3, FST + 40'h3020), 64'(fetches), 64'(f0 + 1));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) flags[i] = 8'h67;
    rst_n = 1'b0; cfg_global_en = 1'b1; cfg_ctx_en = 1'b1; cfg_flush = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_disabled();
    t_miss_hit();
    t_replace();
    t_bounds();
    t_perm();
    t_outside();
    t_flush();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule